// File: doc/BRIEF.md
# Three-Level Flattened Page-Table Walker

This block resolves a virtual page number into a physical frame by reading page-table entries from memory. The 48-bit virtual address uses 4 KB pages, so a request carries a 36-bit virtual page number together with the physical base address of the root table. The usual bottom two 9-bit radix levels are fused into one flat last level indexed by 18 bits. A full walk therefore takes three dependent memory reads instead of four.

Each read fetches one 8-byte entry at the current table base plus eight times the index for that level. Every read is tagged so that the memory system steers it around the small first-level data cache. An entry whose present bit is clear ends the walk at once with a fault. Only one walk is in flight at a time. The requester sees `req_ready` low from acceptance until the result has been taken on the response handshake.

Top module: `ptw_flat3`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0.
- R2: The first read of a walk goes to `req_root + 8*vpn[35:27]`.
- R3: The second read goes to `{P0,12'h000} + 8*vpn[26:18]`, where P0 is bits [51:12] of the first entry.
- R4: The third read goes to `{P1,12'h000} + 8*vpn[17:0]`. This uses the full 18-bit flat index, and P1 is bits [51:12] of the second entry.
- R5: When all three entries have bit 0 (present) set, the walk makes exactly three reads. It then responds with `rsp_fault`=0, `rsp_level`=2 and `rsp_ppn` equal to bits [51:12] of the third entry.
- R6: Every memory read is issued with `mem_req_nocache`=1.
- R7: An entry read at level L (0 = root, 2 = flat) with bit 0 clear ends the walk with no further read. The response is `rsp_fault`=1, `rsp_level`=L and `rsp_ppn`=0.
- R8: `req_ready` is 0 from a request's acceptance until its response handshake. A request offered during that time has no effect: it starts no read and no walk.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, the response stays valid and its fields stay unchanged.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid with an unchanged address.
- R11: At most one memory read is outstanding. No read is requested between an accepted read and its `mem_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walk request offered |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_root | input | 52 | Physical base address of the root table |
| req_vpn | input | 36 | Virtual page number to translate |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Physical byte address of the entry |
| mem_req_nocache | output | 1 | Read bypasses the first-level cache |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry contents |
| rsp_valid | output | 1 | Walk result available |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_fault | output | 1 | Walk ended on a non-present entry |
| rsp_level | output | 2 | Level of the last entry read |
| rsp_ppn | output | 40 | Physical frame number, zero on fault |

## Verification
The hardest situations to reach from the ports are a fault on the flat level and a request offered while a finished result is still held. Both only occur deep into a walk. The bench builds per-test page tables in a sparse memory model. It places the non-present entry at a chosen level and uses all-ones indices to exercise the full 18-bit flat offset. It then holds `rsp_ready` low while offering a second request with a different page number. Memory-side stalls and multi-cycle read latency are added so that the hold rules on both handshakes are exercised mid-walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    parameter int VA_W     = 48;
    parameter int OFF_W    = 12;
    parameter int IDX_W    = 9;
    parameter int FLAT_W   = 2 * IDX_W;
    parameter int PA_W     = 52;
    parameter int PTE_W    = 64;
    parameter int LEVELS   = 3;
    parameter int ENTRY_SH = 3;

    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int LVL_W = $clog2(LEVELS);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_ISSUE,
        WS_WAIT,
        WS_DONE
    } walk_state_e;

    typedef struct packed {
        logic             present;
        logic [PPN_W-1:0] ppn;
    } pte_view_t;

    typedef struct packed {
        logic             fault;
        logic [LVL_W-1:0] level;
        logic [PPN_W-1:0] ppn;
    } walk_result_t;

    function automatic logic [PA_W-1:0] frame_base(input logic [PPN_W-1:0] ppn);
        return {ppn, {OFF_W{1'b0}}};
    endfunction
endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel
    import ptw_pkg::*;
(
    input  logic [VPN_W-1:0] vpn,
    input  logic [LVL_W-1:0] lvl,
    input  logic [PA_W-1:0]  table_base,
    output logic [PA_W-1:0]  entry_addr
);
    logic [FLAT_W-1:0] idx_by_lvl [LEVELS];
    logic [FLAT_W-1:0] idx;

    genvar g;
    generate
        for (g = 0; g < LEVELS; g++) begin : g_lvl
            if (g == LEVELS - 1) begin : g_flat
                assign idx_by_lvl[g] = vpn[FLAT_W-1:0];
            end else begin : g_radix
                localparam int LO = FLAT_W + (LEVELS - 2 - g) * IDX_W;
                assign idx_by_lvl[g] = FLAT_W'(vpn[LO +: IDX_W]);
            end
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (lvl == LVL_W'(i)) idx = idx_by_lvl[i];
        end
    end

    assign entry_addr = table_base + (PA_W'(idx) << ENTRY_SH);
endmodule

// File: rtl/ptw_pte_unpack.sv
module ptw_pte_unpack
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] raw,
    output pte_view_t        view
);
    logic [PTE_W-PA_W-1:0] unused_hi;
    logic [OFF_W-2:0]      unused_lo;

    assign view.present = raw[0];
    assign view.ppn     = raw[PA_W-1:OFF_W];
    assign unused_hi    = raw[PTE_W-1:PA_W];
    assign unused_lo    = raw[OFF_W-1:1];
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [PA_W-1:0]  req_root,
    input  logic [VPN_W-1:0] req_vpn,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    input  logic             mem_rsp_valid,
    input  pte_view_t        pte,
    output logic [VPN_W-1:0] cur_vpn,
    output logic [LVL_W-1:0] cur_lvl,
    output logic [PA_W-1:0]  cur_base,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output walk_result_t     result
);
    walk_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= WS_IDLE;
            cur_vpn  <= '0;
            cur_lvl  <= '0;
            cur_base <= '0;
            result   <= '0;
        end else begin
            case (state)
                WS_IDLE: begin
                    if (req_valid) begin
                        cur_vpn  <= req_vpn;
                        cur_base <= req_root;
                        cur_lvl  <= '0;
                        state    <= WS_ISSUE;
                    end
                end
                WS_ISSUE: begin
                    if (mem_req_ready) state <= WS_WAIT;
                end
                WS_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!pte.present) begin
                            result <= '{fault: 1'b1, level: cur_lvl, ppn: '0};
                            state  <= WS_DONE;
                        end else if (cur_lvl == LAST_LVL) begin
                            result <= '{fault: 1'b0, level: cur_lvl, ppn: pte.ppn};
                            state  <= WS_DONE;
                        end else begin
                            cur_base <= frame_base(pte.ppn);
                            cur_lvl  <= cur_lvl + 1'b1;
                            state    <= WS_ISSUE;
                        end
                    end
                end
                WS_DONE: begin
                    if (rsp_ready) state <= WS_IDLE;
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

    assign req_ready     = (state == WS_IDLE);
    assign mem_req_valid = (state == WS_ISSUE);
    assign rsp_valid     = (state == WS_DONE);
endmodule

// File: rtl/ptw_flat3.sv
module ptw_flat3
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [PA_W-1:0]  req_root,
    input  logic [VPN_W-1:0] req_vpn,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    output logic             mem_req_nocache,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic             rsp_fault,
    output logic [LVL_W-1:0] rsp_level,
    output logic [PPN_W-1:0] rsp_ppn
);
    pte_view_t        pte;
    walk_result_t     result;
    logic [VPN_W-1:0] cur_vpn;
    logic [LVL_W-1:0] cur_lvl;
    logic [PA_W-1:0]  cur_base;

    ptw_pte_unpack u_unpack (
        .raw  (mem_rsp_data),
        .view (pte)
    );

    ptw_index_sel u_index (
        .vpn        (cur_vpn),
        .lvl        (cur_lvl),
        .table_base (cur_base),
        .entry_addr (mem_req_addr)
    );

    ptw_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_root      (req_root),
        .req_vpn       (req_vpn),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .pte           (pte),
        .cur_vpn       (cur_vpn),
        .cur_lvl       (cur_lvl),
        .cur_base      (cur_base),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .result        (result)
    );

    // Entry reads always steer around the first-level cache.
    assign mem_req_nocache = 1'b1;
    assign rsp_fault       = result.fault;
    assign rsp_level       = result.level;
    assign rsp_ppn         = result.ppn;
endmodule

// File: rtl/ptw_flat3_chk.sv
module ptw_flat3_chk
    import ptw_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [PA_W-1:0]  mem_req_addr,
    input logic             mem_rsp_valid,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic             rsp_fault,
    input logic [LVL_W-1:0] rsp_level,
    input logic [PPN_W-1:0] rsp_ppn
);
    logic       outstanding;
    logic [2:0] reads_in_walk;

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding   <= 1'b0;
            reads_in_walk <= '0;
        end else begin
            if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
            else if (mem_rsp_valid)             outstanding <= 1'b0;
            if (req_valid && req_ready)              reads_in_walk <= '0;
            else if (mem_req_valid && mem_req_ready) reads_in_walk <= reads_in_walk + 1'b1;
        end
    end

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R9
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_fault)
                                    && $stable(rsp_level) && $stable(rsp_ppn));

    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);

    // R8
    no_accept_with_result_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    // R11
    single_read_chk: assert property (@(posedge clk) disable iff (rst)
        outstanding && !mem_rsp_valid |-> !mem_req_valid);

    // R5
    read_budget_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> reads_in_walk < 3'd3);

    // R7
    fault_no_ppn_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault |-> rsp_ppn == '0);
endmodule

bind ptw_flat3 ptw_flat3_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_fault     (rsp_fault),
    .rsp_level     (rsp_level),
    .rsp_ppn       (rsp_ppn)
);

// File: tb/ptw_flat3_bench.sv
`timescale 1ns/1ps
module ptw_flat3_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [51:0] req_root = '0;
    logic [35:0] req_vpn = '0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [51:0] mem_req_addr;
    logic        mem_req_nocache;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_fault;
    logic [1:0]  rsp_level;
    logic [39:0] rsp_ppn;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    ptw_flat3 u_ptw_flat3 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_root(req_root), .req_vpn(req_vpn),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_nocache(mem_req_nocache),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_fault(rsp_fault), .rsp_level(rsp_level), .rsp_ppn(rsp_ppn)
    );

    // Sparse memory model with configurable latency and request stalls.
    logic [63:0] mem [logic [51:0]];
    int          mem_lat = 0;
    int          stall_cfg = 0;
    int          stall_left = 0;
    logic [51:0] log_addr [0:7];
    logic        log_nc [0:7];
    int          n_reads = 0;
    int          overlap_err = 0;
    int          hold_err = 0;
    bit          rd_busy = 0;
    int          rd_wait = 0;
    logic [51:0] rd_addr = '0;
    logic [51:0] held_addr = '0;
    bit          holding = 0;

    assign mem_req_ready = (stall_left == 0);

    initial forever begin
        @(posedge clk);
        mem_rsp_valid <= 1'b0;
        if (rd_busy) begin
            if (mem_req_valid) overlap_err++;
            if (rd_wait == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem.exists(rd_addr) ? mem[rd_addr] : 64'h0;
                rd_busy = 0;
            end else begin
                rd_wait--;
            end
        end
        if (mem_req_valid && !mem_req_ready) begin
            if (holding && held_addr != mem_req_addr) hold_err++;
            held_addr = mem_req_addr;
            holding = 1;
            stall_left <= stall_left - 1;
        end
        if (mem_req_valid && mem_req_ready) begin
            if (holding && held_addr != mem_req_addr) hold_err++;
            holding = 0;
            if (n_reads < 8) begin
                log_addr[n_reads] = mem_req_addr;
                log_nc[n_reads]   = mem_req_nocache;
            end
            n_reads++;
            rd_addr = mem_req_addr;
            rd_busy = 1;
            rd_wait = mem_lat;
            stall_left <= stall_cfg;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_pte(input logic [39:0] ppn, input bit present);
        return {12'h0, ppn, 11'h0, present};
    endfunction

    logic [51:0] e_addr [0:2];

    // Build tables for one walk; fail_lvl 3 means every entry is present.
    task automatic build(input logic [51:0] root, input logic [35:0] vpn,
                         input logic [39:0] t1, input logic [39:0] t2,
                         input logic [39:0] frame, input int fail_lvl);
        mem.delete();
        e_addr[0] = root + 52'(vpn[35:27]) * 8;
        e_addr[1] = {t1, 12'h0} + 52'(vpn[26:18]) * 8;
        e_addr[2] = {t2, 12'h0} + 52'(vpn[17:0]) * 8;
        mem[e_addr[0]] = mk_pte(t1, fail_lvl != 0);
        mem[e_addr[1]] = mk_pte(t2, fail_lvl != 1);
        mem[e_addr[2]] = mk_pte(frame, fail_lvl != 2);
    endtask

    task automatic walk(input string tag, input logic [51:0] root, input logic [35:0] vpn,
                        input int exp_reads, input bit exp_fault, input logic [1:0] exp_lvl,
                        input logic [39:0] exp_ppn, input int hold);
        int t;
        logic       s_fault;
        logic [1:0] s_lvl;
        logic [39:0] s_ppn;
        int         reads_at_end;
        n_reads = 0;
        stall_left = stall_cfg;
        @(negedge clk);
        req_root  = root;
        req_vpn   = vpn;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, {tag, " R8 busy after accept"}, 64'(req_ready), 64'd0);
        t = 0;
        while (!rsp_valid && t < 400) begin
            @(negedge clk);
            t++;
        end
        chk(rsp_valid == 1'b1, {tag, " R5 response arrives"}, 64'(rsp_valid), 64'd1);
        chk(n_reads == exp_reads, {tag, " R5/R7 read count"}, 64'(n_reads), 64'(exp_reads));
        for (int i = 0; i < exp_reads && i < 3; i++) begin
            chk(log_addr[i] == e_addr[i],
                $sformatf("%s R%0s entry address level %0d", tag, i == 0 ? "2" : (i == 1 ? "3" : "4"), i),
                64'(log_addr[i]), 64'(e_addr[i]));
            chk(log_nc[i] == 1'b1, {tag, " R6 nocache attribute"}, 64'(log_nc[i]), 64'd1);
        end
        chk(rsp_fault == exp_fault, {tag, " R7 fault flag"}, 64'(rsp_fault), 64'(exp_fault));
        chk(rsp_level == exp_lvl, {tag, " R7 level"}, 64'(rsp_level), 64'(exp_lvl));
        chk(rsp_ppn == exp_ppn, {tag, " R5 frame"}, 64'(rsp_ppn), 64'(exp_ppn));
        chk(overlap_err == 0, {tag, " R11 one read outstanding"}, 64'(overlap_err), 64'd0);
        chk(hold_err == 0, {tag, " R10 address held under stall"}, 64'(hold_err), 64'd0);
        if (hold > 0) begin
            s_fault = rsp_fault;
            s_lvl   = rsp_level;
            s_ppn   = rsp_ppn;
            req_vpn   = ~vpn;
            req_valid = 1'b1;
            for (int k = 0; k < hold; k++) begin
                @(negedge clk);
                chk(rsp_valid && rsp_fault == s_fault && rsp_level == s_lvl && rsp_ppn == s_ppn,
                    {tag, " R9 response held"}, {rsp_valid, 21'h0, rsp_ppn, rsp_level}, {1'b1, 21'h0, s_ppn, s_lvl});
                chk(req_ready == 1'b0, {tag, " R8 no accept while holding"}, 64'(req_ready), 64'd0);
            end
            req_valid = 1'b0;
        end
        reads_at_end = n_reads;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(rsp_valid == 1'b0 && req_ready == 1'b1, {tag, " R8 idle after handshake"},
            64'({rsp_valid, req_ready}), 64'b01);
        repeat (4) @(negedge clk);
        chk(n_reads == reads_at_end && !mem_req_valid, {tag, " R8 ignored request starts nothing"},
            64'(n_reads), 64'(reads_at_end));
    endtask

    task automatic t_reset;
        chk(req_ready == 1'b1, "R1 req_ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
    endtask

    task automatic t_full_walk;
        mem_lat = 0; stall_cfg = 0;
        build(52'h0_0000_0000_1000, 36'h1_2345_6789, 40'h00_0000_0042, 40'h00_0000_0777, 40'hAB_CDEF_0123, 3);
        walk("full-walk R2 R3 R4", 52'h0_0000_0000_1000, 36'h1_2345_6789, 3, 1'b0, 2'd2, 40'hAB_CDEF_0123, 0);
    endtask

    task automatic t_max_index;
        mem_lat = 3; stall_cfg = 0;
        build(52'h0_0000_0080_0008, 36'hF_FFFF_FFFF, 40'h12_3456_7800, 40'hFF_FFFF_0000, 40'hFF_FFFF_FFFF, 3);
        walk("max-index R4", 52'h0_0000_0080_0008, 36'hF_FFFF_FFFF, 3, 1'b0, 2'd2, 40'hFF_FFFF_FFFF, 0);
    endtask

    task automatic t_faults;
        mem_lat = 1; stall_cfg = 0;
        build(52'h0_0000_0000_2000, 36'h0_0804_0201, 40'h00_0000_0010, 40'h00_0000_0020, 40'h00_0000_0030, 0);
        walk("fault-root R7", 52'h0_0000_0000_2000, 36'h0_0804_0201, 1, 1'b1, 2'd0, 40'h0, 0);
        build(52'h0_0000_0000_2000, 36'h0_0804_0201, 40'h00_0000_0010, 40'h00_0000_0020, 40'h00_0000_0030, 1);
        walk("fault-mid R7", 52'h0_0000_0000_2000, 36'h0_0804_0201, 2, 1'b1, 2'd1, 40'h0, 0);
        build(52'h0_0000_0000_2000, 36'h0_0804_0201, 40'h00_0000_0010, 40'h00_0000_0020, 40'h00_0000_0030, 2);
        walk("fault-flat R7", 52'h0_0000_0000_2000, 36'h0_0804_0201, 3, 1'b1, 2'd2, 40'h0, 0);
    endtask

    task automatic t_mem_stall;
        mem_lat = 2; stall_cfg = 4;
        build(52'h0_0000_0005_5000, 36'h5_5AA5_5A5A, 40'h00_0001_1111, 40'h00_0002_2222, 40'h33_3333_3333, 3);
        walk("mem-stall R10", 52'h0_0000_0005_5000, 36'h5_5AA5_5A5A, 3, 1'b0, 2'd2, 40'h33_3333_3333, 0);
        stall_cfg = 0;
    endtask

    task automatic t_rsp_hold;
        mem_lat = 0; stall_cfg = 0;
        build(52'h0_0000_0000_3000, 36'h2_0040_0ABC, 40'h00_0000_0101, 40'h00_0000_0202, 40'h0F_0F0F_0F0F, 3);
        walk("rsp-hold R9", 52'h0_0000_0000_3000, 36'h2_0040_0ABC, 3, 1'b0, 2'd2, 40'h0F_0F0F_0F0F, 6);
        build(52'h0_0000_0000_3000, 36'h2_0040_0ABC, 40'h00_0000_0101, 40'h00_0000_0202, 40'h0F_0F0F_0F0F, 1);
        walk("fault-hold R9", 52'h0_0000_0000_3000, 36'h2_0040_0ABC, 2, 1'b1, 2'd1, 40'h0, 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_full_walk();
        t_max_index();
        t_faults();
        t_mem_stall();
        t_rsp_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule